// File: doc/BRIEF.md
# Extended Capability List Walker

This engine walks the chain of extended capability headers held in a 4 KB configuration space. It reaches that space through a single-port dword interface. A read returns its data one cycle after the request. A select field picks one of four parallel arrays: configuration data, write-enable mask, write-one-to-clear mask and compare mask. Each 32-bit header carries a capability ID in bits 15:0, a version in bits 19:16 and a next pointer in bits 31:20. The chain always begins at byte offset 0x100.

Two commands are accepted through a start/busy/done handshake:

- **Lookup** searches the chain for an ID. It reports the offset where the ID was found and the offset of the header visited just before it.
- **Append** attaches a new header at the end of the chain, or writes it in place at 0x100. It then makes the new byte range read-only in the mask arrays.

A malformed chain ends the walk with an error flag instead of letting it run forever. Malformed means a pointer that is out of range, a pointer that is misaligned, or a chain that loops.

Top module: `ext_cap_walker`

## Requirements
- R1: When the dword at 0x100 reads as all zeros, a lookup for any ID (including 0) finishes without error with result offset 0 and previous offset 0.
- R2: A lookup follows next pointers (header bits 31:20) from 0x100. It stops at the first header whose bits 15:0 equal the key, and reports that header's offset and the offset visited before it (0 if the match is at 0x100).
- R3: When no header matches, the lookup reports offset 0 and, as previous offset, the last header visited, which is the one whose next field is 0.
- R4: A lookup with key 0 on a non-empty chain whose headers carry non-zero IDs returns offset 0 with the previous offset pointing at the tail.
- R5: A next pointer below 0x100, above 0xFF8 or with bits 1:0 not zero ends the command with err high, and no read is ever issued outside dword addresses 0x40..0x3FE.
- R6: A walk reads at most MAX_HOPS headers. A chain that needs more ends with err high.
- R7: An append at offset 0x100 writes {old next field of 0x100, version, ID} there, keeping the existing bits 31:20.
- R8: An append at any other offset rewrites only bits 31:20 of the tail header to the new offset and writes {12'h000, version, ID} at the new offset. The result offset is the new offset and the previous offset is the tail. If the chain is empty, or contains a header with ID 0, the append fails with err.
- R9: An append whose offset is below 0x100, not dword aligned, whose size is below 8, or whose offset plus size is 4096 or more, ends with err and writes nothing.
- R10: After a valid append, every byte in [offset, offset+size) reads 0 in the write mask (select 1) and the W1C mask (select 2) and 0xFF in the compare mask (select 3). Bytes outside the range are untouched (byte enables on the last dword).
- R11: A start pulse while busy is high is ignored: it neither changes the running command nor causes a second done.
- R12: busy is high from the cycle after an accepted start through the done cycle. done is a single-cycle pulse. Results and err hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken when idle |
| cmd_append | input | 1 | 1 = append, 0 = lookup |
| cmd_id | input | 16 | Capability ID (lookup key or new ID) |
| cmd_ver | input | 4 | Version for append |
| cmd_off | input | 12 | Byte offset of the new header (append) |
| cmd_size | input | 13 | Byte size of the new region (append) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command failed |
| res_off | output | 12 | Found offset / new offset |
| res_prev | output | 12 | Previous offset / tail offset |
| mem_rd | output | 1 | Read request (configuration array) |
| mem_wr | output | 1 | Write request |
| mem_space | output | 2 | Array select: 0 config, 1 write mask, 2 W1C mask, 3 compare mask |
| mem_addr | output | 10 | Dword address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |

## Verification
The assertions rely on the memory returning read data exactly one cycle after mem_rd. They also rely on start being sampled only as a request, never as a level that must persist. The bench models the four arrays itself, answers every read with one-cycle latency, and drives start for a single cycle from the falling edge. Chains that are corrupted, looped or empty are built by writing the bench memory directly between commands, never while the engine is busy.

// File: rtl/ext_cap_walker.sv
module ext_cap_walker #(
  parameter int MAX_HOPS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cmd_append,
  input  logic [15:0] cmd_id,
  input  logic [3:0]  cmd_ver,
  input  logic [11:0] cmd_off,
  input  logic [12:0] cmd_size,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [11:0] res_off,
  output logic [11:0] res_prev,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [1:0]  mem_space,
  output logic [9:0]  mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [11:0] BASE = 12'h100;
  localparam logic [11:0] LAST = 12'hFF8;
  localparam int HW = $clog2(MAX_HOPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_EVAL, S_WTAIL, S_WHDR, S_MASK, S_DONE} st_t;
  st_t st;

  logic          app_q;
  logic [15:0]   id_q;
  logic [3:0]    ver_q;
  logic [11:0]   off_q, cur, prv, mptr;
  logic [12:0]   end_q;
  logic [31:0]   hdr;
  logic [HW-1:0] hops;
  logic [1:0]    msp;
  logic [3:0]    mbe;

  logic [13:0] cmd_end;
  logic        append_ok;
  assign cmd_end   = {2'b00, cmd_off} + {1'b0, cmd_size};
  assign append_ok = cmd_off >= BASE && cmd_off[1:0] == 2'b00 &&
                     cmd_size >= 13'd8 && cmd_end < 14'd4096;

  logic [15:0] key;
  logic [11:0] nxt;
  logic        empty, hit, bad_nxt;
  assign key     = app_q ? 16'h0000 : id_q;
  assign nxt     = mem_rdata[31:20];
  assign empty   = cur == BASE && mem_rdata == 32'h0;
  assign hit     = mem_rdata[15:0] == key;
  assign bad_nxt = nxt < BASE || nxt > LAST || nxt[1:0] != 2'b00 || hops >= HW'(MAX_HOPS);

  always_comb begin
    for (int b = 0; b < 4; b++)
      mbe[b] = ({1'b0, mptr} + 13'(b)) < end_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; app_q <= 1'b0; id_q <= '0; ver_q <= '0; off_q <= '0; end_q <= '0;
      cur <= '0; prv <= '0; hdr <= '0; hops <= '0; mptr <= '0; msp <= 2'd1;
      err <= 1'b0; res_off <= '0; res_prev <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          app_q <= cmd_append; id_q <= cmd_id; ver_q <= cmd_ver; off_q <= cmd_off;
          end_q <= cmd_end[12:0]; cur <= BASE; prv <= '0; hops <= '0;
          err <= 1'b0; res_off <= '0; res_prev <= '0;
          if (cmd_append && !append_ok) begin err <= 1'b1; st <= S_DONE; end
          else st <= S_RD;
        end
        S_RD: begin hops <= hops + 1'b1; st <= S_EVAL; end
        S_EVAL: begin
          hdr <= mem_rdata;
          if (app_q && off_q == BASE) begin
            res_prev <= '0; st <= S_WHDR;
          end else if (empty) begin
            err <= app_q; st <= S_DONE;
          end else if (hit) begin
            res_off <= cur; res_prev <= prv; err <= app_q; st <= S_DONE;
          end else if (nxt == 12'h0) begin
            res_prev <= cur; st <= app_q ? S_WTAIL : S_DONE;
          end else if (bad_nxt) begin
            err <= 1'b1; st <= S_DONE;
          end else begin
            prv <= cur; cur <= nxt; st <= S_RD;
          end
        end
        S_WTAIL: st <= S_WHDR;
        S_WHDR: begin res_off <= off_q; mptr <= off_q; msp <= 2'd1; st <= S_MASK; end
        S_MASK: begin
          if (msp == 2'd3) begin
            msp <= 2'd1; mptr <= mptr + 12'd4;
            if (({1'b0, mptr} + 13'd4) >= end_q) st <= S_DONE;
          end else msp <= msp + 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign mem_rd    = st == S_RD;
  assign mem_wr    = st == S_WTAIL || st == S_WHDR || st == S_MASK;
  assign mem_space = st == S_MASK ? msp : 2'd0;
  assign mem_addr  = st == S_MASK ? mptr[11:2] : st == S_WHDR ? off_q[11:2] : cur[11:2];
  assign mem_be    = st == S_MASK ? mbe : 4'hF;
  assign mem_wdata = st == S_WTAIL ? {off_q, hdr[19:0]} :
                     st == S_WHDR  ? {hdr[31:20], ver_q, id_q} : {32{msp == 2'd3}};

  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= 10'h040 && mem_addr <= 10'h3FE)); // R5
  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hops <= HW'(MAX_HOPS)); // R6
  AST_BAD_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cmd_append && !append_ok) |=> (done && err && !mem_wr)); // R9
  AST_MASK_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_space != 2'd0) |-> ({mem_addr, 2'b00} >= off_q && {1'b0, mem_addr, 2'b00} < end_q)); // R10
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(id_q) && $stable(app_q))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R12
endmodule

// File: tb/sim_ext_cap_walker.sv
module sim_ext_cap_walker;
  localparam int MAXH = 1024;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, cmd_append = 0;
  logic [15:0] cmd_id = '0;
  logic [3:0] cmd_ver = '0;
  logic [11:0] cmd_off = '0;
  logic [12:0] cmd_size = '0;
  logic busy, done, err, mem_rd, mem_wr;
  logic [11:0] res_off, res_prev;
  logic [1:0] mem_space;
  logic [9:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  ext_cap_walker #(.MAX_HOPS(MAXH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_append(cmd_append), .cmd_id(cmd_id),
    .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size), .busy(busy), .done(done),
    .err(err), .res_off(res_off), .res_prev(res_prev), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  logic [31:0] mem [4][1024];
  logic [31:0] rmem [4][1024];
  int checks = 0, errors = 0, cyc = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[0][i] = 0; mem[1][i] = '1; mem[2][i] = '1; mem[3][i] = 0;
      rmem[0][i] = 0; rmem[1][i] = '1; rmem[2][i] = '1; rmem[3][i] = 0;
    end
    mem_rdata = 0;
  end

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[0][mem_addr];
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_space][mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; $display("FAIL watchdog expired"); summary_and_end();
    end
  end

  // per-clock protocol comparison
  always @(negedge clk) if (rst_n) begin
    checks++;
    if ((mem_rd && mem_wr) || (!busy && (mem_rd || mem_wr)) || (done && !busy)) begin
      errors++;
      $display("FAIL R12 protocol rd=%0b wr=%0b busy=%0b done=%0b expected idle-quiet", mem_rd, mem_wr, busy, done);
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(int boff, logic [31:0] v);
    mem[0][boff >> 2] = v; rmem[0][boff >> 2] = v;
  endtask

  task automatic ref_find(int key, output int off, output int prev, output bit e);
    int cur = 'h100, hops = 0;
    logic [31:0] h;
    int nx;
    off = 0; prev = 0; e = 0;
    forever begin
      h = rmem[0][cur >> 2]; hops++;
      if (cur == 'h100 && h == 0) return;
      if (int'(h[15:0]) == key) begin off = cur; return; end
      nx = int'(h[31:20]);
      if (nx == 0) begin prev = cur; return; end
      if (nx < 'h100 || nx > 'hFF8 || (nx % 4) != 0 || hops >= MAXH) begin e = 1; return; end
      prev = cur; cur = nx;
    end
  endtask

  task automatic ref_append(int id, int ver, int off, int size, output int ro, output int rp, output bit e);
    int fo, fp; bit fe;
    ro = off; rp = 0; e = 0;
    if (off < 'h100 || off % 4 != 0 || size < 8 || off + size >= 4096) begin e = 1; return; end
    if (off == 'h100) begin
      rmem[0][64] = {rmem[0][64][31:20], 4'(ver), 16'(id)};
    end else begin
      ref_find(0, fo, fp, fe);
      if (fe || fo != 0 || fp < 'h100) begin e = 1; return; end
      rmem[0][fp >> 2][31:20] = 12'(off);
      rmem[0][off >> 2] = {12'h000, 4'(ver), 16'(id)};
      rp = fp;
    end
    for (int a = off; a < off + size; a++) begin
      rmem[1][a >> 2][8*(a%4) +: 8] = 8'h00;
      rmem[2][a >> 2][8*(a%4) +: 8] = 8'h00;
      rmem[3][a >> 2][8*(a%4) +: 8] = 8'hFF;
    end
  endtask

  task automatic issue(bit app, int id, int ver, int off, int size);
    @(negedge clk);
    start = 1; cmd_append = app; cmd_id = 16'(id); cmd_ver = 4'(ver);
    cmd_off = 12'(off); cmd_size = 13'(size);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, req, "done seen", done, 1);
  endtask

  task automatic cmp_mem(string req);
    for (int s = 0; s < 4; s++) begin
      int bad = -1;
      for (int i = 0; i < 1024; i++) if (bad < 0 && mem[s][i] !== rmem[s][i]) bad = i;
      if (bad < 0) chk(1, req, "array", 0, 0);
      else chk(0, req, $sformatf("array %0d dword %0h", s, bad), mem[s][bad], rmem[s][bad]);
    end
  endtask

  task automatic do_find(int key, string req);
    int eo, ep; bit ee;
    ref_find(key, eo, ep, ee);
    issue(0, key, 0, 0, 0);
    chk(busy, "R12", "busy after start", busy, 1);
    wait_done(req);
    chk(err == ee, req, $sformatf("err key %0h", key), err, ee);
    if (!ee) begin
      chk(res_off == 12'(eo), req, $sformatf("offset key %0h", key), res_off, eo);
      chk(res_prev == 12'(ep), req, $sformatf("prev key %0h", key), res_prev, ep);
    end
    @(negedge clk);
    chk(!done && !busy, "R12", "done single pulse", done, 0);
  endtask

  task automatic do_append(int id, int ver, int off, int size, string req);
    int eo, ep; bit ee;
    ref_append(id, ver, off, size, eo, ep, ee);
    issue(1, id, ver, off, size);
    wait_done(req);
    chk(err == ee, req, "append err", err, ee);
    if (!ee) begin
      chk(res_off == 12'(eo), req, "append offset", res_off, eo);
      chk(res_prev == 12'(ep), req, "append prev", res_prev, ep);
    end
    @(negedge clk);
    cmp_mem(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R12", "reset quiet", {busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    do_find('h0001, "R1");
    do_find('h0000, "R1");
    do_append('h0001, 'h0, 'h150, 8, "R8");        // empty chain: append elsewhere fails
    do_append('h000B, 'h1, 'h100, 'h30, "R10");
    do_append('h0010, 'h2, 'h200, 'h0D, "R10");    // partial last dword
    do_append('h0003, 'h1, 'h150, 8, "R8");
    do_find('h0003, "R2");
    do_find('h000B, "R2");
    do_find('h0010, "R2");
    do_find('h7777, "R3");
    do_find('h0000, "R4");
    do_append('h0022, 'h3, 'h100, 8, "R7");
    chk(mem[0][64][31:20] == 12'h200, "R7", "next kept", mem[0][64][31:20], 12'h200);
    do_find('h0003, "R2");
    do_append('h0040, 'h1, 'h0F0, 16, "R9");
    do_append('h0040, 'h1, 'h300, 4, "R9");
    do_append('h0040, 'h1, 'hFF8, 8, "R9");
    do_append('h0040, 'h1, 'h302, 8, "R9");
    poke('h150, 32'h0801_0003); do_find('h7777, "R5");
    poke('h150, 32'hFFC1_0003); do_find('h7777, "R5");
    poke('h150, 32'h3021_0003); do_find('h7777, "R5");
    do_append('h0041, 'h1, 'h400, 8, "R5");
    poke('h150, 32'h1501_0003); do_find('h7777, "R6");
    do_find('h0003, "R6");
    begin : r11_blk
      int eo, ep; bit ee;
      ref_find('h7777, eo, ep, ee);
      issue(0, 'h7777, 0, 0, 0);
      repeat (4) @(negedge clk);
      start = 1; cmd_append = 1; cmd_id = 16'h0055; cmd_off = 12'h500; cmd_size = 13'd16;
      @(negedge clk); start = 0;
      wait_done("R11");
      chk(err == ee, "R11", "first command kept", err, ee);
      @(negedge clk);
      for (int k = 0; k < 10; k++) begin
        chk(!done && !busy, "R11", "no second done", done, 0);
        @(negedge clk);
      end
      cmp_mem("R11");
    end
    poke('h150, 32'h0001_0003); do_find('h7777, "R3");
    summary_and_end();
  end
endmodule